// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block models a small synchronous static RAM that never needs an idle cycle between reads and writes. Every rising clock edge can carry a new command. A write command is captured with its address, and its data follows on a later edge: one edge later in flow-through mode and two edges later in pipelined mode. Read data appears after the command edge in flow-through mode. In pipelined mode it passes through an output register first. Because write data lags its command, a read can land on an address whose write data is still on its way. In pipelined mode the block merges that data into the read, lane by lane.

Commands are accepted only while three chip-select inputs are all in their active state. A burst-advance input steps through four consecutive locations from the last loaded address. The order is either linear or interleaved, chosen by a static input. An asynchronous output-enable input turns the read data off at any time. An asynchronous sleep input freezes the block.

Top module: `zt_sram`

## Requirements
- R1: A new command is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 with `adv`=0. Any other select combination with `adv`=0 is a deselect: nothing is written, no read data is produced, and any running burst ends.
- R2: A read captured at edge k drives `q_oe`=1 with the read word in the cycle after edge k in flow-through mode (`pipe_mode`=0). In pipelined mode (`pipe_mode`=1) this happens in the cycle after edge k+1. In both cases `oe_n` must be 0 and `sleep` must be 0.
- R3: The data for a write captured at edge k is taken from `wdata` at edge k+1 in flow-through mode and at edge k+2 in pipelined mode.
- R4: Reads and writes in any order, and to any addresses, run on consecutive edges with no idle cycle. Every read returns the most recently written contents.
- R5: `lane_wr[i]`=1 writes `wdata` bits [9i+8:9i] of the word. A lane whose bit is 0 keeps its old contents.
- R6: In pipelined mode, a read that immediately follows a write to the same address returns the pending write data in the enabled lanes, and the stored contents in the other lanes.
- R7: With `ilv_order`=0, each `adv`=1 cycle during a live burst accesses the loaded address with its low 2 bits replaced by (start + n) mod 4, where n is the count of advances so far. The upper bits stay unchanged. The burst keeps the read or write type it was loaded with.
- R8: With `ilv_order`=1, the low 2 bits on the n-th advance are start XOR n.
- R9: An `adv`=1 cycle when no burst is live (after reset or after a deselect) is a deselect. The select, `wr` and `addr` inputs are ignored on any `adv`=1 cycle.
- R10: `oe_n`=1 forces `q_oe` to 0 at once, without waiting for a clock edge.
- R11: While `sleep`=1, `q_oe` is 0, commands are discarded, and no array location or pipeline state changes.
- R12: `q` is all zeros whenever `q_oe` is 0.
- R13: After reset, `q_oe` is 0 and no burst is live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline (not the array) |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| ilv_order | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | Burst advance: continue the live burst |
| wr | input | 1 | Command type on a load: 1 write, 0 read |
| lane_wr | input | LANES | Per-lane write enables, sampled with each write beat's command |
| addr | input | ADDR_W | Word address for a load |
| wdata | input | DATA_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep: freezes the block and disables the output |
| q | output | DATA_W | Read data, zero when not enabled |
| q_oe | output | 1 | Enable for the data pad drivers |

## Verification
The hardest situation to reach from the ports is a pipelined read that lands on a write whose data has not arrived yet, especially with only one lane enabled. A forwarding bug only shows when the address matches exactly and the lane mask is partial. The stimulus therefore confines random addresses to sixteen words, mixes reads, writes and burst advances on consecutive edges, and draws random lane masks. The expected word comes from a reference array that the bench updates on the edge each write's data is actually due. Directed sequences add the write-then-read pair, a four-beat write burst read back in both orders, an advance after a deselect, and writes attempted during sleep.

// File: rtl/zt_pkg.sv
package zt_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zt_op_e;

   // low two address bits of the n-th beat of a four-beat burst
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] count,
                                           input logic       interleave);
      return interleave ? (start ^ count) : (start + count);
   endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load,
   input  logic              load_wr,
   input  logic              adv,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr,
   output zt_op_e            op,
   output logic [ADDR_W-1:0] eff_addr
);

   localparam int LOW_W = 2;

   if (ADDR_W < LOW_W + 1) begin : g_chk_aw
      $error("zt_burst_seq: ADDR_W must exceed the burst field width");
   end

   logic [ADDR_W-1:0] base_q;
   logic [LOW_W-1:0]  cnt_q;
   logic              live_q;
   logic              bwr_q;
   logic [LOW_W-1:0]  cnt_nx;
   logic              cont;

   assign cont   = adv && live_q;
   assign cnt_nx = cnt_q + 1'b1;

   always_comb begin
      if (load) begin
         op       = load_wr ? OP_WRITE : OP_READ;
         eff_addr = addr;
      end else if (cont) begin
         op       = bwr_q ? OP_WRITE : OP_READ;
         eff_addr = {base_q[ADDR_W-1:LOW_W], beat_low(base_q[LOW_W-1:0], cnt_nx, ilv)};
      end else begin
         op       = OP_IDLE;
         eff_addr = base_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         live_q <= 1'b0;
         bwr_q  <= 1'b0;
      end else if (!hold) begin
         if (load) begin
            base_q <= addr;
            cnt_q  <= '0;
            live_q <= 1'b1;
            bwr_q  <= load_wr;
         end else if (cont) begin
            cnt_q  <= cnt_nx;
         end else begin
            live_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/zt_cmd_stages.sv
module zt_cmd_stages
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  zt_op_e            in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [LANES-1:0]  in_lanes,
   output zt_op_e            s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_lanes,
   output zt_op_e            s2_op,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_lanes
);

   if (STAGES != 2) begin : g_chk_st
      $error("zt_cmd_stages: exactly two command stages are supported");
   end

   zt_op_e            op_q   [STAGES];
   logic [ADDR_W-1:0] addr_q [STAGES];
   logic [LANES-1:0]  ln_q   [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op_q[g]   <= OP_IDLE;
               addr_q[g] <= '0;
               ln_q[g]   <= '0;
            end else if (!hold) begin
               op_q[g]   <= in_op;
               addr_q[g] <= in_addr;
               ln_q[g]   <= in_lanes;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op_q[g]   <= OP_IDLE;
               addr_q[g] <= '0;
               ln_q[g]   <= '0;
            end else if (!hold) begin
               op_q[g]   <= op_q[g-1];
               addr_q[g] <= addr_q[g-1];
               ln_q[g]   <= ln_q[g-1];
            end
         end
      end
   end

   assign s1_op    = op_q[0];
   assign s1_addr  = addr_q[0];
   assign s1_lanes = ln_q[0];
   assign s2_op    = op_q[1];
   assign s2_addr  = addr_q[1];
   assign s2_lanes = ln_q[1];

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wlanes,
   input  logic [BYTE_W*LANES-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [BYTE_W*LANES-1:0] rdata
);

   localparam int WORDS = 1 << ADDR_W;

   if (WORDS * LANES > 4096) begin : g_chk_size
      $error("zt_lane_array: array larger than this model allows");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] mem [WORDS];

      always_ff @(posedge clk) begin
         if (we && wlanes[g]) mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      end

      assign rdata[g*BYTE_W +: BYTE_W] = mem[raddr];
   end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int LANES  = 2,
   localparam int DATA_W = BYTE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              ilv_order,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              adv,
   input  logic              wr,
   input  logic [LANES-1:0]  lane_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DATA_W-1:0] q,
   output logic              q_oe
);

   if (BYTE_W < 1 || LANES < 1) begin : g_chk_lane
      $error("zt_sram: lane geometry must be non-empty");
   end

   logic              sel_all;
   logic              load;
   zt_op_e            cmd_op;
   logic [ADDR_W-1:0] cmd_addr;

   zt_op_e            s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s1_lanes, s2_lanes;

   logic              commit_we;
   logic [ADDR_W-1:0] commit_addr;
   logic [LANES-1:0]  commit_lanes;
   logic [DATA_W-1:0] arr_rd;
   logic [DATA_W-1:0] merged;
   logic              fwd_hit;

   logic [DATA_W-1:0] q_reg;
   logic              q_vld_r;
   logic              read_vld;
   logic [DATA_W-1:0] read_dat;

   assign sel_all = !sel_a_n && sel_b && !sel_c_n;
   assign load    = sel_all && !adv;

   zt_burst_seq #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .load     (load),
      .load_wr  (wr),
      .adv      (adv),
      .ilv      (ilv_order),
      .addr     (addr),
      .op       (cmd_op),
      .eff_addr (cmd_addr)
   );

   zt_cmd_stages #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(2)) u_stages (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .in_op    (cmd_op),
      .in_addr  (cmd_addr),
      .in_lanes (lane_wr),
      .s1_op    (s1_op),
      .s1_addr  (s1_addr),
      .s1_lanes (s1_lanes),
      .s2_op    (s2_op),
      .s2_addr  (s2_addr),
      .s2_lanes (s2_lanes)
   );

   // late write: data lags one edge (flow-through) or two edges (pipelined)
   always_comb begin
      if (pipe_mode) begin
         commit_we    = !sleep && (s2_op == OP_WRITE);
         commit_addr  = s2_addr;
         commit_lanes = s2_lanes;
      end else begin
         commit_we    = !sleep && (s1_op == OP_WRITE);
         commit_addr  = s1_addr;
         commit_lanes = s1_lanes;
      end
   end

   zt_lane_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_array (
      .clk    (clk),
      .we     (commit_we),
      .waddr  (commit_addr),
      .wlanes (commit_lanes),
      .wdata  (wdata),
      .raddr  (s1_addr),
      .rdata  (arr_rd)
   );

   // pipelined read captured while an older write's data is on the bus
   assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && s2_lanes[g])
                                        ? wdata[g*BYTE_W +: BYTE_W]
                                        : arr_rd[g*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_reg   <= '0;
         q_vld_r <= 1'b0;
      end else if (!sleep) begin
         q_vld_r <= (s1_op == OP_READ);
         if (s1_op == OP_READ) q_reg <= merged;
      end
   end

   assign read_vld = pipe_mode ? q_vld_r : (s1_op == OP_READ);
   assign read_dat = pipe_mode ? q_reg : arr_rd;
   assign q_oe     = read_vld && !oe_n && !sleep;
   assign q        = q_oe ? read_dat : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pipe_mode,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              adv,
   input logic              oe_n,
   input logic              sleep,
   input logic [DATA_W-1:0] q,
   input logic              q_oe,
   input zt_op_e            s1_op,
   input logic [ADDR_W-1:0] s1_addr
);

   a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !adv && !(!sel_a_n && sel_b && !sel_c_n)) |=> (s1_op == OP_IDLE));

   a_r2_pipe_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && !sleep && s1_op == OP_READ) |=> (q_oe || oe_n || sleep));

   a_r7_burst_page: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && adv && s1_op != OP_IDLE) |=>
         (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) && s1_op == $past(s1_op)));

   a_r9_dead_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && adv && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

   a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !q_oe);

   a_r11_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !q_oe);

   a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(s1_addr) && $stable(s1_op)));

   a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !q_oe |-> (q == '0));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pipe_mode (pipe_mode),
   .sel_a_n   (sel_a_n),
   .sel_b     (sel_b),
   .sel_c_n   (sel_c_n),
   .adv       (adv),
   .oe_n      (oe_n),
   .sleep     (sleep),
   .q         (q),
   .q_oe      (q_oe),
   .s1_op     (s1_op),
   .s1_addr   (s1_addr)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;

   localparam int AW = 8;
   localparam int BW = 9;
   localparam int NL = 2;
   localparam int DW = BW * NL;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_mode = 1'b0;
   logic          ilv_order = 1'b0;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b0;
   logic          sel_c_n = 1'b1;
   logic          adv = 1'b0;
   logic          wr = 1'b0;
   logic [NL-1:0] lane_wr = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          oe_n = 1'b0;
   logic          sleep = 1'b0;
   logic [DW-1:0] q;
   logic          q_oe;

   always #4 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .BYTE_W(BW), .LANES(NL)) i_zt_sram (
      .clk, .rst_n, .pipe_mode, .ilv_order, .sel_a_n, .sel_b, .sel_c_n,
      .adv, .wr, .lane_wr, .addr, .wdata, .oe_n, .sleep, .q, .q_oe
   );

   int total = 0;
   int bad = 0;
   int step = 0;

   logic [DW-1:0] ref_mem [WORDS];
   logic          sl_rd    [8];
   logic [AW-1:0] sl_addr  [8];
   logic [DW-1:0] sl_exp   [8];
   string         sl_tag   [8];
   logic          sl_wr    [8];
   logic [AW-1:0] sl_waddr [8];
   logic [NL-1:0] sl_lanes [8];

   logic          b_live = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   logic          b_wr = 1'b0;

   function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] n);
      return ilv_order ? (s ^ n) : (s + n);
   endfunction

   task automatic clear_slots();
      for (int i = 0; i < 8; i++) begin
         sl_rd[i] = 1'b0;
         sl_wr[i] = 1'b0;
      end
   endtask

   task automatic chk_out(input int cur);
      logic exp_oe;
      exp_oe = sl_rd[cur] && !sleep;
      total++;
      if (q_oe !== exp_oe) begin
         bad++;
         $display("FAIL R2 step %0d: q_oe=%0b expected %0b", step, q_oe, exp_oe);
      end
      total++;
      if (exp_oe) begin
         if (q !== sl_exp[cur]) begin
            bad++;
            $display("FAIL %s step %0d addr %0h: q=%h expected %h",
                     sl_tag[cur], step, sl_addr[cur], q, sl_exp[cur]);
         end
      end else if (q !== '0) begin
         bad++;
         $display("FAIL R12 step %0d: q=%h expected 0", step, q);
      end
   endtask

   // kind: 0 deselect, 1 read, 2 write, 3 advance
   task automatic do_step(input int kind, input logic [AW-1:0] a,
                          input logic [NL-1:0] ln, input string tag);
      int lat, cur, nx, idx, isop;
      logic [2:0] p;
      logic [AW-1:0] eff;
      lat = pipe_mode ? 2 : 1;
      cur = step % 8;
      @(negedge clk);
      chk_out(cur);
      if (sl_rd[cur] && ($urandom % 6 == 0)) begin
         oe_n = 1'b1;
         #1;
         total++;
         if (q_oe !== 1'b0 || q !== '0) begin
            bad++;
            $display("FAIL R10 step %0d: q_oe=%0b q=%h expected 0 0", step, q_oe, q);
         end
         oe_n = 1'b0;
         #1;
         total++;
         if (q_oe !== 1'b1) begin
            bad++;
            $display("FAIL R10 step %0d: q_oe=%0b expected 1", step, q_oe);
         end
      end
      sl_rd[cur] = 1'b0;
      wdata = DW'($urandom);
      if (sl_wr[cur]) begin
         for (int l = 0; l < NL; l++)
            if (sl_lanes[cur][l]) ref_mem[sl_waddr[cur]][l*BW +: BW] = wdata[l*BW +: BW];
         sl_wr[cur] = 1'b0;
      end
      sleep = 1'b0;
      adv = 1'b0;
      lane_wr = ln;
      addr = a;
      wr = 1'b0;
      {sel_a_n, sel_b, sel_c_n} = 3'b010;
      eff = a;
      isop = 0;
      case (kind)
         0: begin
            p = 3'($urandom);
            if (p == 3'b010) p = 3'b110;
            {sel_a_n, sel_b, sel_c_n} = p;
            wr = 1'($urandom);
            b_live = 1'b0;
         end
         1, 2: begin
            wr = (kind == 2);
            b_live = 1'b1;
            b_base = a;
            b_cnt = 2'd0;
            b_wr = (kind == 2);
            isop = kind;
         end
         default: begin
            adv = 1'b1;
            {sel_a_n, sel_b, sel_c_n} = 3'($urandom);
            wr = 1'($urandom);
            addr = AW'($urandom);
            if (b_live) begin
               b_cnt = b_cnt + 2'd1;
               eff = {b_base[AW-1:2], exp_low(b_base[1:0], b_cnt)};
               isop = b_wr ? 2 : 1;
            end
         end
      endcase
      idx = (step + lat) % 8;
      if (isop == 1) begin
         sl_rd[idx] = 1'b1;
         sl_addr[idx] = eff;
         sl_tag[idx] = tag;
      end else if (isop == 2) begin
         sl_wr[idx] = 1'b1;
         sl_waddr[idx] = eff;
         sl_lanes[idx] = ln;
      end
      nx = (step + 1) % 8;
      if (sl_rd[nx]) sl_exp[nx] = ref_mem[sl_addr[nx]];
      step++;
   endtask

   task automatic sleep_step(input logic [AW-1:0] a);
      int cur;
      cur = step % 8;
      @(negedge clk);
      chk_out(cur);
      sl_rd[cur] = 1'b0;
      sleep = 1'b1;
      adv = 1'b0;
      wr = 1'b1;
      lane_wr = '1;
      addr = a;
      wdata = DW'($urandom);
      {sel_a_n, sel_b, sel_c_n} = 3'b010;
      #1;
      total++;
      if (q_oe !== 1'b0) begin
         bad++;
         $display("FAIL R11 step %0d: q_oe=%0b expected 0", step, q_oe);
      end
      step++;
   endtask

   task automatic do_reset(input logic pm, input logic io);
      @(negedge clk);
      rst_n = 1'b0;
      sleep = 1'b0;
      adv = 1'b0;
      {sel_a_n, sel_b, sel_c_n} = 3'b101;
      pipe_mode = pm;
      ilv_order = io;
      clear_slots();
      b_live = 1'b0;
      repeat (2) @(negedge clk);
      total++;
      if (q_oe !== 1'b0 || q !== '0) begin
         bad++;
         $display("FAIL R13: q_oe=%0b q=%h expected 0 0", q_oe, q);
      end
      rst_n = 1'b1;
   endtask

   task automatic directed();
      string btag;
      btag = ilv_order ? "R8" : "R7";
      do_step(2, 8'h40, 2'b11, "");
      do_step(1, 8'h40, 2'b00, pipe_mode ? "R6" : "R3");
      do_step(2, 8'h41, 2'b01, "");
      do_step(1, 8'h41, 2'b00, pipe_mode ? "R6" : "R5");
      do_step(2, 8'h42, 2'b10, "");
      do_step(0, 8'h42, 2'b00, "");
      do_step(0, 8'h42, 2'b00, "");
      do_step(1, 8'h42, 2'b00, "R5");
      do_step(0, 8'h43, 2'b11, "");
      do_step(1, 8'h43, 2'b00, "R1");
      do_step(2, 8'h52, 2'b11, "");
      for (int i = 0; i < 3; i++) do_step(3, 8'h00, 2'b11, "");
      do_step(1, 8'h52, 2'b00, btag);
      for (int i = 0; i < 3; i++) do_step(3, 8'h00, 2'b00, btag);
      do_step(2, 8'h60, 2'b11, "");
      do_step(0, 8'h60, 2'b00, "");
      do_step(3, 8'h60, 2'b11, "");
      do_step(1, 8'h61, 2'b00, "R9");
      for (int i = 0; i < 3; i++) do_step(0, 8'h00, 2'b00, "");
      for (int i = 0; i < 3; i++) sleep_step(8'h70);
      do_step(0, 8'h00, 2'b00, "");
      do_step(1, 8'h70, 2'b00, "R11");
      do_step(0, 8'h00, 2'b00, "");
   endtask

   task automatic random_mix(input int n);
      int r;
      for (int i = 0; i < n; i++) begin
         r = $urandom % 10;
         if (r == 0)      do_step(0, AW'($urandom % 16), NL'($urandom), "");
         else if (r < 4)  do_step(1, AW'($urandom % 16), NL'($urandom), "R4");
         else if (r < 7)  do_step(2, AW'($urandom % 16), NL'($urandom), "");
         else             do_step(3, 8'h00, NL'($urandom), ilv_order ? "R8" : "R7");
      end
      for (int i = 0; i < 3; i++) do_step(0, 8'h00, 2'b00, "");
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'd20240611);
      do_reset(1'b0, 1'b0);
      for (int a = 0; a < WORDS; a++) do_step(2, AW'(a), 2'b11, "");
      for (int i = 0; i < 3; i++) do_step(0, 8'h00, 2'b00, "");
      for (int ph = 0; ph < 4; ph++) begin
         do_reset(ph[1], ph[0]);
         directed();
         random_mix(600);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule